// File: doc/BRIEF.md
# Timing-Error-Tolerant Pipeline Register

This block is one pipeline register stage intended to run on a clock that is faster than its worst-case input path permits. On each rising edge of the main clock it captures the incoming word into a main register, which drives the stage output. On each rising edge of a second clock, which has the same period but lags by a fixed phase, it captures the same word again into a backup register. By that later edge the word is known to have settled, so the backup copy is trusted.

Before the next main edge, the block compares the main copy with the backup copy of the same word. If the two differ in any bit, the main capture was wrong. A late-arriving word, or a half-resolved capture that has settled to either value, both count as a difference. In that case, on the next main edge the stage loads the backup value into the output, pulses an error flag for one cycle, and raises a recovery flag for a fixed number of cycles. While recovery lasts, upstream logic holds its word steady, and the stage ignores any new input until the last recovery edge. The phase lag must stay below the shortest path delay into the stage. If it does not, the backup register would catch the next word instead of the current one.

Top module: `timing_guard_stage`

## Requirements
- R1: A synchronous active-high reset, sampled on the main clock, clears the output word, the error flag and the recovery flag to 0. Asserting it while a recovery is in progress ends that recovery.
- R2: When the input word is stable before a main clock edge and recovery is not active, the output shows that word from that edge onward and the error flag stays low.
- R3: The backup register captures the input on the lagging clock edge. The comparison uses the main and backup copies of the same word and takes effect at the following main edge. An error is therefore never flagged in the cycle where the faulty capture happened.
- R4: If the main and backup copies differ in any bit, including a single bit, then at the next main edge the output takes the backup value and the error flag goes high.
- R5: The error flag is high for exactly one main clock cycle for each detected mismatch.
- R6: The recovery flag goes high together with the error flag and stays high for RECOVER_CYCLES main clock cycles (default 2).
- R7: While the recovery flag is high, the output holds the restored word and input changes are ignored. The main register next accepts the input on the edge where the recovery flag falls.
- R8: No comparison is made for the cycles in which the main register did not take the input. An input change during recovery therefore causes no error.
- R9: A late input change that does not alter the value of the word causes no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock; the output register and the control logic run on its rising edge |
| clk_ps_i | input | 1 | Phase-lagged copy of the main clock that clocks the backup register |
| rst_i | input | 1 | Synchronous active-high reset |
| din_i | input | WIDTH | Word from the upstream logic |
| dout_o | output | WIDTH | Registered word (main register) |
| err_o | output | 1 | One-cycle pulse when a capture mismatch has been corrected |
| recover_o | output | 1 | High while the stage is restoring and holding the corrected word |

## Verification
A stale or wrongly reset backup copy appears at the ports as a spurious error pulse one main cycle after the next capture. A restore from the wrong source shows as a wrong output word in the very cycle the error pulse is high. A recovery counter with the wrong load value or the wrong decrement changes how long the recovery flag stays high. It also moves the cycle in which a new input word first reaches the output, so the fault is visible within RECOVER_CYCLES+1 cycles of the error. A comparison left enabled during recovery shows as an extra error pulse right after recovery ends, when the input changed during the hold.

// File: rtl/tegp_shadow_capture.sv
`timescale 1ns/1ps
module tegp_shadow_capture #(
    parameter int WIDTH = 16
) (
    input  logic             clk_ps_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] shadow_o
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } shadow_state_t;

    shadow_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.data = din_i;
    end

    always_ff @(posedge clk_ps_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign shadow_o = st_q.data;
endmodule

// File: rtl/tegp_recovery_ctrl.sv
`timescale 1ns/1ps
module tegp_recovery_ctrl #(
    parameter int WIDTH          = 16,
    parameter int RECOVER_CYCLES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] main_i,
    input  logic [WIDTH-1:0] shadow_i,
    output logic             load_din_o,
    output logic             load_shadow_o,
    output logic             err_o,
    output logic             recover_o
);
    localparam int CW = $clog2(RECOVER_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(RECOVER_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          cmp_valid;
        logic          err;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        mismatch;

    always_comb begin
        st_d          = st_q;
        st_d.err      = 1'b0;
        load_din_o    = 1'b0;
        load_shadow_o = 1'b0;
        mismatch      = st_q.cmp_valid && (main_i != shadow_i);
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_LAST) begin
                load_din_o     = 1'b1;
                st_d.cmp_valid = 1'b1;
            end else begin
                st_d.cmp_valid = 1'b0;
            end
        end else if (mismatch) begin
            load_shadow_o  = 1'b1;
            st_d.err       = 1'b1;
            st_d.cnt       = CNT_LOAD;
            st_d.cmp_valid = 1'b0;
        end else begin
            load_din_o     = 1'b1;
            st_d.cmp_valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign err_o     = st_q.err;
    assign recover_o = (st_q.cnt != '0);

    initial begin
        assert_recover_param_R6: assert (RECOVER_CYCLES >= 1)
            else $error("RECOVER_CYCLES must be at least 1");
    end

    assert_err_single_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |=> !err_o);

    assert_recover_starts_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(recover_o) |-> err_o);

    assert_count_bounded_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= CNT_LOAD);
endmodule

// File: rtl/tegp_main_capture.sv
`timescale 1ns/1ps
module tegp_main_capture #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic [WIDTH-1:0] shadow_i,
    input  logic             load_din_i,
    input  logic             load_shadow_i,
    output logic [WIDTH-1:0] main_o
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } main_state_t;

    main_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_shadow_i)   st_d.data = shadow_i;
        else if (load_din_i) st_d.data = din_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign main_o = st_q.data;

    assert_load_exclusive_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !(load_din_i && load_shadow_i));
endmodule

// File: rtl/timing_guard_stage.sv
`timescale 1ns/1ps
module timing_guard_stage #(
    parameter int WIDTH          = 16,
    parameter int RECOVER_CYCLES = 2
) (
    input  logic             clk_i,
    input  logic             clk_ps_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             err_o,
    output logic             recover_o
);
    logic [WIDTH-1:0] shadow_q;
    logic [WIDTH-1:0] main_q;
    logic             load_din;
    logic             load_shadow;

    tegp_shadow_capture #(.WIDTH(WIDTH)) i_shadow (
        .clk_ps_i (clk_ps_i),
        .rst_i    (rst_i),
        .din_i    (din_i),
        .shadow_o (shadow_q)
    );

    tegp_recovery_ctrl #(.WIDTH(WIDTH), .RECOVER_CYCLES(RECOVER_CYCLES)) i_ctrl (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .main_i        (main_q),
        .shadow_i      (shadow_q),
        .load_din_o    (load_din),
        .load_shadow_o (load_shadow),
        .err_o         (err_o),
        .recover_o     (recover_o)
    );

    tegp_main_capture #(.WIDTH(WIDTH)) i_main (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .din_i         (din_i),
        .shadow_i      (shadow_q),
        .load_din_i    (load_din),
        .load_shadow_i (load_shadow),
        .main_o        (main_q)
    );

    assign dout_o = main_q;

    assert_reset_clears_R1: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!err_o && !recover_o && dout_o == '0));

    assert_detect_prior_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |-> $past(main_q != shadow_q));

    assert_restore_value_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |-> (dout_o == $past(shadow_q)));

    assert_hold_output_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (recover_o && !err_o) |-> $stable(dout_o));
endmodule

// File: tb/test_timing_guard_stage.sv
`timescale 1ns/1ps
module test_timing_guard_stage;
    localparam int W   = 16;
    localparam int REC = 2;

    logic         clk = 1'b0;
    logic         clk_ps = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         err;
    logic         rec;
    int           n_checks = 0;
    int           n_errs = 0;

    always #2.5 clk = ~clk;
    initial begin
        #1.0;
        forever #2.5 clk_ps = ~clk_ps;
    end

    timing_guard_stage #(.WIDTH(W), .RECOVER_CYCLES(REC)) i_timing_guard_stage (
        .clk_i     (clk),
        .clk_ps_i  (clk_ps),
        .rst_i     (rst),
        .din_i     (din),
        .dout_o    (dout),
        .err_o     (err),
        .recover_o (rec)
    );

    task automatic check_word(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_flag(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    // Word driven well before the next main edge; sampled 2 ns after it.
    task automatic drive_ok(input string tag, input logic [W-1:0] v);
        @(posedge clk);
        #2.5 din = v;
        @(posedge clk);
        #2.0;
        check_word({tag, " dout"}, dout, v);
        check_flag({tag, " err"}, err, 1'b0);
        check_flag({tag, " rec"}, rec, 1'b0);
    endtask

    // Word changes 0.5 ns after a main edge: main misses it, backup catches it.
    // Returns 2 ns after the edge at which the error is flagged.
    task automatic late_change(input string tag, input logic [W-1:0] old_v, input logic [W-1:0] v);
        @(posedge clk);
        #0.5 din = v;
        #1.5;
        check_word({tag, " R3 no early restore"}, dout, old_v);
        check_flag({tag, " R3 no early err"}, err, 1'b0);
        @(posedge clk);
        #2.0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2.0;
        check_word("R1 reset dout", dout, '0);
        check_flag("R1 reset err", err, 1'b0);
        check_flag("R1 reset rec", rec, 1'b0);
        #0.5 rst = 1'b0;
    endtask

    task automatic t_normal();
        drive_ok("R2 all ones", 16'hFFFF);
        drive_ok("R2 all zeros", 16'h0000);
        drive_ok("R2 pattern a", 16'hA5A5);
        drive_ok("R2 pattern b", 16'h5A5A);
        for (int i = 0; i < 4; i++) begin
            drive_ok("R2 walking", W'(16'h0001 << (i * 4)));
        end
    endtask

    task automatic t_late_error();
        drive_ok("R2 base", 16'h1234);
        late_change("late", 16'h1234, 16'hBEEF);
        check_word("R4 restored dout", dout, 16'hBEEF);
        check_flag("R4 err high", err, 1'b1);
        check_flag("R6 rec high first", rec, 1'b1);
        @(posedge clk); #2.0;
        check_flag("R5 err one cycle", err, 1'b0);
        check_flag("R6 rec high second", rec, 1'b1);
        check_word("R7 dout held", dout, 16'hBEEF);
        @(posedge clk); #2.0;
        check_flag("R6 rec low after count", rec, 1'b0);
        check_word("R7 dout after recovery", dout, 16'hBEEF);
        @(posedge clk); #2.0;
        check_flag("R8 no err after recovery", err, 1'b0);
    endtask

    task automatic t_change_during_hold();
        drive_ok("R2 base2", 16'h0F0F);
        late_change("hold", 16'h0F0F, 16'h3C3C);
        check_flag("R4 err hold case", err, 1'b1);
        #0.5 din = 16'hC3C3;
        @(posedge clk); #2.0;
        check_word("R7 input ignored in hold", dout, 16'h3C3C);
        check_flag("R8 no err in hold", err, 1'b0);
        @(posedge clk); #2.0;
        check_word("R7 input taken at last recovery edge", dout, 16'hC3C3);
        check_flag("R6 rec low", rec, 1'b0);
        @(posedge clk); #2.0;
        check_flag("R8 no spurious err", err, 1'b0);
        check_word("R2 word kept", dout, 16'hC3C3);
    endtask

    task automatic t_same_value();
        drive_ok("R2 base3", 16'h7777);
        late_change("same", 16'h7777, 16'h7777);
        check_flag("R9 no err for same value", err, 1'b0);
        check_flag("R9 no rec for same value", rec, 1'b0);
        check_word("R9 dout unchanged", dout, 16'h7777);
    endtask

    task automatic t_single_bit();
        drive_ok("R2 base4", 16'h8000);
        late_change("bit", 16'h8000, 16'h8001);
        check_flag("R4 single bit err", err, 1'b1);
        check_word("R4 single bit restore", dout, 16'h8001);
        repeat (REC) @(posedge clk);
        #2.0;
        check_flag("R6 rec done single bit", rec, 1'b0);
    endtask

    task automatic t_back_to_back();
        drive_ok("R2 base5", 16'h1111);
        late_change("b2b first", 16'h1111, 16'h2222);
        check_flag("R4 first err", err, 1'b1);
        @(posedge clk); #2.0;
        @(posedge clk); #2.0;
        check_word("R7 b2b resumed", dout, 16'h2222);
        late_change("b2b second", 16'h2222, 16'h4444);
        check_flag("R4 second err", err, 1'b1);
        check_word("R4 second restore", dout, 16'h4444);
        repeat (REC) @(posedge clk);
        #2.0;
        check_flag("R6 b2b rec done", rec, 1'b0);
    endtask

    task automatic t_reset_mid_recovery();
        drive_ok("R2 base6", 16'h0101);
        late_change("rst mid", 16'h0101, 16'h9999);
        check_flag("R6 rec before reset", rec, 1'b1);
        #0.5 rst = 1'b1;
        @(posedge clk); #2.0;
        check_flag("R1 reset ends recovery", rec, 1'b0);
        check_flag("R1 reset clears err", err, 1'b0);
        check_word("R1 reset clears dout", dout, '0);
        #0.5 rst = 1'b0;
        @(posedge clk); #2.0;
        check_word("R2 capture after reset", dout, 16'h9999);
        @(posedge clk); #2.0;
        check_flag("R1 no err after reset", err, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_normal();
        t_late_error();
        t_change_during_hold();
        t_same_value();
        t_single_bit();
        t_back_to_back();
        t_reset_mid_recovery();
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule